// File: doc/BRIEF.md
# Metaframe Framing Generator with CRC-32

This block sits on the transmit side of a serial lane. Every clock cycle it sends out one 64-bit word and a flag that marks the word as control or data. It groups the outgoing words into metaframes of a fixed length, `MF_LEN`, which is set by a parameter between 5 and 8192. Each metaframe contains four framing words that the block builds itself: a synchronization word, a scrambler-state word, a skip word and a diagnostic word. The remaining slots carry payload, which the block pulls from an upstream first-word-fall-through FIFO.

A payload slot is filled from the FIFO only when two conditions hold: the FIFO reports data, and the burst gate allows a read (when `BURST_CTRL` is set). Otherwise the block sends an idle control word in that slot. Idle words still count toward the metaframe length, so the framing cadence never changes.

A running CRC-32 covers every word of the metaframe, including the diagnostic word itself. The result is placed in the low 32 bits of the diagnostic word. A per-word error-insert strobe corrupts the CRC on purpose, so that a receiver's checker can be tested.

Top module: `ilk_mframe_gen`

## Requirements
- R1: While `rst_n` is low, `tx_word` is the idle word 0x1C00000000000000, `tx_ctl` is 1, and `mf_start` and `pl_rd` are 0. The first word after reset is released is a synchronization word.
- R2: Slot 0 of every metaframe carries 0x78F678F678F678F6. Slot 1 carries {6'b001010, SCRM_SEED[57:0]}. Slot MF_LEN-2 carries the skip word 0x3A1E1E1E1E1E1E1E. Slot MF_LEN-1 carries the diagnostic word. All four framing words have `tx_ctl`=1.
- R3: `pl_rd` is a combinational output. It can be high only in payload slots 2..MF_LEN-3, and only while `pl_avail` is high. The popped `pl_data` appears on `tx_word` one cycle later, with `tx_ctl`=0.
- R4: A payload slot in which no word is popped carries the idle word 0x1C00000000000000 with `tx_ctl`=1. This slot still counts toward `MF_LEN`.
- R5: `mf_start` is high exactly in the cycles in which the synchronization word is on `tx_word`. It therefore pulses once every MF_LEN cycles.
- R6: The diagnostic word has the following fields:
  - bits [63:58] = 6'b011001
  - bits [57:34] = 0
  - bits [33:32] = `diag_status`, sampled in the cycle before the word appears
- R7: Bits [31:0] of the diagnostic word hold the complemented CRC-32 over the metaframe. The CRC is computed as follows:
  - polynomial 0x1EDC6F41, register initialised to all ones at the start of each metaframe
  - each word is processed bit 63 first
  - the diagnostic word is included with its CRC field taken as zero
  - `tx_ctl` is not covered by the CRC
- R8: When `crc_err_ins` is high in the cycle before a word appears, the CRC register value after that word's update is bit-inverted. This includes the diagnostic word's own update.
- R9: With BURST_CTRL=1, no FIFO word is popped while `burst_en` is low. The affected payload slots carry idle words instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pl_data | input | 64 | Head word of the upstream FIFO |
| pl_avail | input | 1 | Upstream FIFO holds at least one word |
| burst_en | input | 1 | Read gate for payload slots |
| diag_status | input | 2 | Status message for the diagnostic word |
| crc_err_ins | input | 1 | Corrupt the CRC update of the word now being formed |
| tx_word | output | 64 | Outgoing lane word |
| tx_ctl | output | 1 | 1 = control word, 0 = payload |
| pl_rd | output | 1 | Pop strobe to the upstream FIFO |
| mf_start | output | 1 | High with the first word of each metaframe |

## Verification
The bench uses a short metaframe, so that the wrap from the diagnostic slot back to the synchronization slot happens dozens of times. Along the way it steps through several patterns:
- full throughput
- a sparse FIFO
- a toggling burst gate
- error strobes that sometimes land on the diagnostic word itself

A design that popped in a framing slot, or that let idle slots shift the cadence, would misplace the sync word and `mf_start`. A design that seeded the CRC with the final field instead of zero, or that forgot to reset the CRC between metaframes, would send a wrong diagnostic CRC. A design that applied the error strobe to the wrong word would do the same.

// File: rtl/ilk_mframe_pkg.sv
package ilk_mframe_pkg;

   localparam int WORD_W = 64;
   localparam int CRC_W  = 32;

   localparam logic [CRC_W-1:0]  CRC_POLY  = 32'h1EDC_6F41;
   localparam logic [WORD_W-1:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
   localparam logic [WORD_W-1:0] SKIP_WORD = 64'h3A1E_1E1E_1E1E_1E1E;
   localparam logic [WORD_W-1:0] IDLE_WORD = 64'h1C00_0000_0000_0000;
   localparam logic [5:0]        SCRM_TAG  = 6'b001010;
   localparam logic [5:0]        DIAG_TAG  = 6'b011001;

   typedef enum logic [2:0] {
      SL_SYNC,
      SL_SCRM,
      SL_PAY,
      SL_SKIP,
      SL_DIAG
   } slot_kind_t;

endpackage

// File: rtl/ilk_mframe_slot.sv
module ilk_mframe_slot
   import ilk_mframe_pkg::*;
#(
   parameter int MF_LEN = 16,
   localparam int POS_W = $clog2(MF_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [POS_W-1:0] pos,
   output slot_kind_t       kind
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(MF_LEN - 1);
   localparam logic [POS_W-1:0] SKIP_POS = POS_W'(MF_LEN - 2);

   always_ff @(posedge clk) begin
      if (!rst_n)               pos <= '0;
      else if (pos == LAST_POS) pos <= '0;
      else                      pos <= pos + 1'b1;
   end

   always_comb begin
      if (pos == '0)               kind = SL_SYNC;
      else if (pos == POS_W'(1))   kind = SL_SCRM;
      else if (pos == SKIP_POS)    kind = SL_SKIP;
      else if (pos == LAST_POS)    kind = SL_DIAG;
      else                         kind = SL_PAY;
   end

endmodule

// File: rtl/ilk_mframe_crc.sv
module ilk_mframe_crc
   import ilk_mframe_pkg::*;
(
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [WORD_W-1:0] word,
   input  logic              flip,
   output logic [CRC_W-1:0]  crc_out
);

   logic [CRC_W-1:0] stage [WORD_W+1];

   assign stage[0] = crc_in;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      logic fb;
      assign fb = stage[i][CRC_W-1] ^ word[WORD_W-1-i];
      assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
   end

   assign crc_out = flip ? ~stage[WORD_W] : stage[WORD_W];

endmodule

// File: rtl/ilk_mframe_gen.sv
module ilk_mframe_gen
   import ilk_mframe_pkg::*;
#(
   parameter int          MF_LEN     = 16,
   parameter bit          BURST_CTRL = 1'b1,
   parameter logic [57:0] SCRM_SEED  = 58'h1F0_F0F0_F0F0_F0F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pl_data,
   input  logic              pl_avail,
   input  logic              burst_en,
   input  logic [1:0]        diag_status,
   input  logic              crc_err_ins,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_ctl,
   output logic              pl_rd,
   output logic              mf_start
);

   localparam int POS_W = $clog2(MF_LEN);

   if (MF_LEN < 5 || MF_LEN > 8192) begin : g_bad_len
      $error("ilk_mframe_gen: MF_LEN must lie in 5..8192");
   end
   if (SCRM_SEED == '0) begin : g_bad_seed
      $error("ilk_mframe_gen: SCRM_SEED must be non-zero");
   end

   logic [POS_W-1:0] pos;
   slot_kind_t       kind;

   ilk_mframe_slot #(.MF_LEN(MF_LEN)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos),
      .kind  (kind)
   );

   logic gate_ok;
   if (BURST_CTRL) begin : g_burst
      assign gate_ok = burst_en;
   end else begin : g_free
      logic unused_burst;
      assign unused_burst = burst_en;
      assign gate_ok      = 1'b1;
   end

   assign pl_rd = (kind == SL_PAY) && pl_avail && gate_ok;

   logic [WORD_W-1:0] base_word;
   logic              base_ctl;

   always_comb begin
      base_ctl = 1'b1;
      unique case (kind)
         SL_SYNC: base_word = SYNC_WORD;
         SL_SCRM: base_word = {SCRM_TAG, SCRM_SEED};
         SL_SKIP: base_word = SKIP_WORD;
         SL_DIAG: base_word = {DIAG_TAG, 24'h0, diag_status, 32'h0};
         default: begin
            if (pl_rd) begin
               base_word = pl_data;
               base_ctl  = 1'b0;
            end else begin
               base_word = IDLE_WORD;
            end
         end
      endcase
   end

   logic [CRC_W-1:0] crc_q, crc_nxt;

   ilk_mframe_crc u_crc (
      .crc_in  (crc_q),
      .word    (base_word),
      .flip    (crc_err_ins),
      .crc_out (crc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q    <= '1;
         tx_word  <= IDLE_WORD;
         tx_ctl   <= 1'b1;
         mf_start <= 1'b0;
      end else begin
         crc_q    <= (kind == SL_DIAG) ? '1 : crc_nxt;
         tx_word  <= (kind == SL_DIAG) ? {base_word[WORD_W-1:CRC_W], ~crc_nxt} : base_word;
         tx_ctl   <= base_ctl;
         mf_start <= (kind == SL_SYNC);
      end
   end

endmodule

// File: rtl/ilk_mframe_chk.sv
module ilk_mframe_chk
   import ilk_mframe_pkg::*;
#(
   parameter int MF_LEN     = 16,
   parameter bit BURST_CTRL = 1'b1,
   localparam int POS_W     = $clog2(MF_LEN)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [POS_W-1:0]  pos,
   input logic              pl_rd,
   input logic              pl_avail,
   input logic              burst_en,
   input logic [WORD_W-1:0] pl_data,
   input logic [WORD_W-1:0] tx_word,
   input logic              tx_ctl,
   input logic              mf_start
);

   logic [POS_W:0] since_sof;
   logic           seen_sof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_sof <= '0;
         seen_sof  <= 1'b0;
      end else if (mf_start) begin
         since_sof <= '0;
         seen_sof  <= 1'b1;
      end else begin
         since_sof <= since_sof + 1'b1;
      end
   end

   AST_RD_IN_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pl_rd |-> (int'(pos) >= 2 && int'(pos) <= MF_LEN - 3));                       // R3
   AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pl_rd |-> pl_avail);                                                           // R3
   AST_RD_DATA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      pl_rd |=> (!tx_ctl && tx_word == $past(pl_data)));                             // R3
   AST_BURST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (BURST_CTRL && !burst_en) |-> !pl_rd);                                         // R9
   AST_SOF_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      mf_start |-> (tx_ctl && tx_word == SYNC_WORD));                                // R5
   AST_SOF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_start && seen_sof) |-> (int'(since_sof) == MF_LEN - 1));                   // R5
   AST_IDLE_IS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_word == IDLE_WORD) |-> tx_ctl);                                            // R4

endmodule

bind ilk_mframe_gen ilk_mframe_chk #(.MF_LEN(MF_LEN), .BURST_CTRL(BURST_CTRL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pos      (pos),
   .pl_rd    (pl_rd),
   .pl_avail (pl_avail),
   .burst_en (burst_en),
   .pl_data  (pl_data),
   .tx_word  (tx_word),
   .tx_ctl   (tx_ctl),
   .mf_start (mf_start)
);

// File: tb/ilk_mframe_gen_bench.sv
`timescale 1ns/1ps
module ilk_mframe_gen_bench;

   localparam int          L    = 7;
   localparam logic [57:0] SEED = 58'h123_4567_89AB_CDEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pl_data = '0;
   logic        pl_avail = 1'b0, burst_en = 1'b0, crc_err_ins = 1'b0;
   logic [1:0]  diag_status = 2'b00;
   logic [63:0] tx_word;
   logic        tx_ctl, pl_rd, mf_start;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   ilk_mframe_gen #(.MF_LEN(L), .BURST_CTRL(1'b1), .SCRM_SEED(SEED)) u_ilk_mframe_gen (
      .clk(clk), .rst_n(rst_n), .pl_data(pl_data), .pl_avail(pl_avail),
      .burst_en(burst_en), .diag_status(diag_status), .crc_err_ins(crc_err_ins),
      .tx_word(tx_word), .tx_ctl(tx_ctl), .pl_rd(pl_rd), .mf_start(mf_start)
   );

   function automatic logic [31:0] crc_bits(logic [31:0] c, logic [63:0] w);
      logic [31:0] r = c;
      for (int b = 63; b >= 0; b--) begin
         if (r[31] != w[b]) r = (r << 1) ^ 32'h1EDC_6F41;
         else               r = r << 1;
      end
      return r;
   endfunction

   function automatic logic [63:0] fifo_word(int n);
      return {32'(n) ^ 32'hA5A5_0F0F, ~(32'(n) * 32'd2654435761)};
   endfunction

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int          mpos = 0, fidx = 0;
      logic [31:0] mcrc = '1;
      logic [63:0] ew = '0;
      logic        ec = 1'b0, es = 1'b0, have = 1'b0, diag_err = 1'b0;
      string       etag = "";
      bit          err_mf = 0;

      repeat (3) @(negedge clk);
      check("R1 reset word", tx_word, 64'h1C00_0000_0000_0000);
      check("R1 reset ctl", 64'(tx_ctl), 64'd1);
      check("R1 reset start", 64'(mf_start), 64'd0);
      check("R1 reset rd", 64'(pl_rd), 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < 420; k++) begin
         if (have) begin
            if (etag == "DIAG") begin
               check("R6 diag header/status", {32'h0, tx_word[63:32]}, {32'h0, ew[63:32]});
               check(diag_err ? "R8 diag crc err" : "R7 diag crc", {32'h0, tx_word[31:0]}, {32'h0, ew[31:0]});
            end else begin
               check(etag, tx_word, ew);
            end
            check({etag, " ctl"}, 64'(tx_ctl), 64'(ec));
            check("R5 start", 64'(mf_start), 64'(es));
         end

         if (k < 100) begin
            pl_avail = 1'b1; burst_en = 1'b1; crc_err_ins = 1'b0;
         end else if (k < 200) begin
            pl_avail = (k % 5) != 3; burst_en = 1'b1; crc_err_ins = (k % 13) == 6;
         end else if (k < 300) begin
            pl_avail = 1'b1; burst_en = ((k / 3) % 2) == 0; crc_err_ins = 1'b0;
         end else begin
            pl_avail = (k % 4) != 0; burst_en = (k % 3) != 1; crc_err_ins = (k % 7) == 6;
         end
         diag_status = 2'(k / 7);
         pl_data = fifo_word(fidx);
         #0.5;

         begin
            logic pay, exp_rd;
            logic [31:0] c;
            pay = (mpos >= 2) && (mpos <= L - 3);
            exp_rd = pay && pl_avail && burst_en;
            check((pay && pl_avail && !burst_en) ? "R9 burst gate" : "R3 read strobe",
                  64'(pl_rd), 64'(exp_rd));
            ec = 1'b1;
            es = (mpos == 0);
            if (mpos == 0)          begin ew = 64'h78F6_78F6_78F6_78F6; etag = "R2 sync"; end
            else if (mpos == 1)     begin ew = {6'b001010, SEED};       etag = "R2 scrambler word"; end
            else if (mpos == L - 2) begin ew = 64'h3A1E_1E1E_1E1E_1E1E; etag = "R2 skip"; end
            else if (mpos == L - 1) begin ew = {6'b011001, 24'h0, diag_status, 32'h0}; etag = "DIAG"; end
            else if (exp_rd)        begin ew = fifo_word(fidx); ec = 1'b0; fidx++; etag = "R3 payload"; end
            else                    begin ew = 64'h1C00_0000_0000_0000; etag = "R4 idle"; end

            c = crc_bits(mcrc, ew);
            if (crc_err_ins) begin c = ~c; err_mf = 1; end
            if (mpos == L - 1) begin
               ew[31:0] = ~c;
               diag_err = err_mf;
               err_mf = 0;
               mcrc = '1;
            end else begin
               mcrc = c;
            end
            mpos = (mpos == L - 1) ? 0 : mpos + 1;
         end
         have = 1'b1;
         @(negedge clk);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule